// File: doc/BRIEF.md
# Processor Presence Map and Hotplug Event Register

This block records which processors in the system are present and raises a level-sensitive system control interrupt when a processor arrives or leaves. The presence record is a 256-bit map with one bit per processor interrupt-controller identifier. Software reads it one byte at a time over a simple I/O bus. A separate side interface carries hot-add and hot-remove requests, each an identifier plus an action, from the platform.

Each request edits one presence bit and also latches a shared processor-hotplug event flag in a small event block. The event block holds two status bytes and two enable bytes. Status bits are cleared by writing ones to them. The interrupt output is a level computed from the enabled pending events. A pulse input latches the neighbouring PCI hotplug event, and one more input stands for any other enabled power-management event that is pending. After handling the interrupt, firmware reads the map to find out which processors changed.

Top module: `cpu_presence_evt`

## Requirements
- R1: When `rst_n` is low at a clock edge, the presence map loads from `boot_map` and all status and enable bits become 0.
- R2: A read at address 0xAF00+n (n from 0 to 31) returns map byte n. Bit b of that byte is the presence of identifier 8*n+b. Data changes combinationally with the address.
- R3: A request with `hp_valid`=1 and `hp_add`=1 sets the map bit of `hp_id` at the next edge. With `hp_add`=0 it clears that bit. Every other map bit keeps its value.
- R4: Bus writes to addresses 0xAF00 through 0xAF1F change no map bit.
- R5: Every accepted request, add or remove, sets status bit 2 at address 0xAFE0. A `pci_evt` pulse sets status bit 1 at that address.
- R6: The status bytes sit at 0xAFE0 and 0xAFE1. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: The enable bytes sit at 0xAFE2 and 0xAFE3. They are plain read/write registers.
- R8: If a set event and a clearing write reach the same status bit at the same edge, the bit ends up set.
- R9: `sci_level` is 1 exactly when (status byte 0 AND enable byte 0) has bit 1 or bit 2 set, or when `pm_other_pend` is 1.
- R10: A read at any address outside 0xAF00-0xAF1F and 0xAFE0-0xAFE3 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_map | input | 256 | Presence map value loaded at reset |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | Write strobe for one byte, taken at the clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` |
| hp_valid | input | 1 | Hotplug request strobe |
| hp_id | input | 8 | Processor identifier for the request |
| hp_add | input | 1 | 1 = hot-add, 0 = hot-remove |
| pci_evt | input | 1 | Latches the PCI hotplug event flag |
| pm_other_pend | input | 1 | Another enabled power-management event is pending |
| sci_level | output | 1 | Level interrupt output |

## Verification
The assertions assume that `hp_id` and `hp_add` are stable whenever `hp_valid` is high. The ignored-write and clearing-write properties also assume that no hotplug request arrives in the same cycle as the write. The bench drives every input on the falling edge and holds each request strobe for exactly one cycle. It issues map writes and status clears only while no request is pending, except in the one deliberate collision case written for R8.

// File: rtl/cpuhp_pkg.sv
package cpuhp_pkg;

  localparam int unsigned CPU_EVT_BIT = 2;
  localparam int unsigned PCI_EVT_BIT = 1;
  localparam logic [7:0]  SCI_MASK    = 8'h06;
  localparam logic [7:0]  UNMAPPED_RD = 8'hFF;

  function automatic logic in_window(input int unsigned addr,
                                     input int unsigned base,
                                     input int unsigned len);
    return (addr >= base) && (addr < base + len);
  endfunction

  function automatic logic sci_from(input logic [7:0] sts_lo,
                                    input logic [7:0] en_lo,
                                    input logic       other);
    return (|(sts_lo & en_lo & SCI_MASK)) | other;
  endfunction

endpackage

// File: rtl/presence_map.sv
module presence_map #(
  parameter int ID_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [(1<<ID_W)-1:0]       boot_map,
  input  logic                       hp_valid,
  input  logic [ID_W-1:0]            hp_id,
  input  logic                       hp_add,
  input  logic [ID_W-4:0]            rd_idx,
  output logic [7:0]                 rd_byte,
  output logic [(1<<ID_W)-1:0]       map_q
);
  localparam int MAP_BITS = 1 << ID_W;

  for (genvar i = 0; i < MAP_BITS; i++) begin : g_bit
    logic hit;
    assign hit = hp_valid && (hp_id == ID_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)   map_q[i] <= boot_map[i];
      else if (hit) map_q[i] <= hp_add;
    end
  end

  assign rd_byte = map_q[{rd_idx, 3'b000} +: 8];
endmodule

// File: rtl/evt_regs.sv
module evt_regs #(
  parameter int LANES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_off,
  input  logic [7:0]           wr_data,
  input  logic                 cpu_evt,
  input  logic                 pci_evt,
  output logic [LANES*8-1:0]   sts_q,
  output logic [LANES*8-1:0]   en_q
);
  import cpuhp_pkg::*;

  logic [LANES*8-1:0] set_vec;
  always_comb begin
    set_vec = '0;
    set_vec[CPU_EVT_BIT] = cpu_evt;
    set_vec[PCI_EVT_BIT] = pci_evt;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic       sts_wr, en_wr;
    logic [7:0] clr;
    assign sts_wr = wr_en && (wr_off == 2'(k));
    assign en_wr  = wr_en && (wr_off == 2'(k + LANES));
    assign clr    = sts_wr ? wr_data : 8'h00;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sts_q[k*8 +: 8] <= 8'h00;
        en_q[k*8 +: 8]  <= 8'h00;
      end else begin
        // set wins over a same-cycle clear (R8)
        sts_q[k*8 +: 8] <= (sts_q[k*8 +: 8] & ~clr) | set_vec[k*8 +: 8];
        if (en_wr) en_q[k*8 +: 8] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/cpu_presence_evt.sv
module cpu_presence_evt #(
  parameter int              ID_W     = 8,
  parameter int              ADDR_W   = 16,
  parameter logic [15:0]     MAP_BASE = 16'hAF00,
  parameter logic [15:0]     EVT_BASE = 16'hAFE0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [255:0]           boot_map,
  input  logic [15:0]            io_addr,
  input  logic                   io_wr,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  input  logic                   hp_valid,
  input  logic [7:0]             hp_id,
  input  logic                   hp_add,
  input  logic                   pci_evt,
  input  logic                   pm_other_pend,
  output logic                   sci_level
);
  import cpuhp_pkg::*;

  localparam int MAP_BITS  = 1 << ID_W;
  localparam int MAP_BYTES = MAP_BITS / 8;
  localparam int IDX_W     = ID_W - 3;
  localparam int EVT_LANES = 2;
  localparam int EVT_PORTS = 2 * EVT_LANES;

  logic                 map_hit, evt_hit;
  logic [IDX_W-1:0]     map_idx;
  logic [1:0]           evt_off;
  logic [7:0]           map_byte;
  logic [MAP_BITS-1:0]  map_q;
  logic [EVT_LANES*8-1:0] sts_q, en_q;

  assign map_hit = in_window(32'(io_addr), 32'(MAP_BASE), MAP_BYTES);
  assign evt_hit = in_window(32'(io_addr), 32'(EVT_BASE), EVT_PORTS);
  assign map_idx = IDX_W'(io_addr - MAP_BASE);
  assign evt_off = 2'(io_addr - EVT_BASE);

  presence_map #(.ID_W(ID_W)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .boot_map (boot_map),
    .hp_valid (hp_valid),
    .hp_id    (hp_id),
    .hp_add   (hp_add),
    .rd_idx   (map_idx),
    .rd_byte  (map_byte),
    .map_q    (map_q)
  );

  evt_regs #(.LANES(EVT_LANES)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (io_wr && evt_hit),
    .wr_off  (evt_off),
    .wr_data (io_wdata),
    .cpu_evt (hp_valid),
    .pci_evt (pci_evt),
    .sts_q   (sts_q),
    .en_q    (en_q)
  );

  always_comb begin
    if (map_hit)      io_rdata = map_byte;
    else if (evt_hit) begin
      case (evt_off)
        2'd0:    io_rdata = sts_q[7:0];
        2'd1:    io_rdata = sts_q[15:8];
        2'd2:    io_rdata = en_q[7:0];
        default: io_rdata = en_q[15:8];
      endcase
    end else          io_rdata = UNMAPPED_RD;
  end

  assign sci_level = sci_from(sts_q[7:0], en_q[7:0], pm_other_pend);
endmodule

// File: rtl/cpu_presence_evt_chk.sv
module cpu_presence_evt_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [15:0]  io_addr,
  input logic         io_wr,
  input logic [7:0]   io_wdata,
  input logic [7:0]   io_rdata,
  input logic         hp_valid,
  input logic [7:0]   hp_id,
  input logic         hp_add,
  input logic         pm_other_pend,
  input logic         sci_level,
  input logic [255:0] map_q,
  input logic [15:0]  sts_q,
  input logic [15:0]  en_q
);
  logic map_w, unmapped;
  assign map_w    = io_wr && (io_addr >= 16'hAF00) && (io_addr < 16'hAF20);
  assign unmapped = !((io_addr >= 16'hAF00 && io_addr < 16'hAF20) ||
                      (io_addr >= 16'hAFE0 && io_addr < 16'hAFE4));

  p_add_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hp_valid && hp_add |=> map_q[$past(hp_id)]);
  p_remove_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hp_valid && !hp_add |=> !map_q[$past(hp_id)]);
  p_map_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    map_w && !hp_valid |=> $stable(map_q));
  p_evt_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hp_valid |=> sts_q[2]);
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_addr == 16'hAFE0 && io_wdata[2] && !hp_valid |=> !sts_q[2]);
  p_enable_rw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr && io_addr == 16'hAFE2 |=> en_q[7:0] == $past(io_wdata));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hp_valid && io_wr && io_addr == 16'hAFE0 |=> sts_q[2]);
  p_sci_cpu_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sts_q[2] && en_q[2] |-> sci_level);
  p_sci_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pm_other_pend |-> sci_level);
  p_sci_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_other_pend && !(sts_q[1] && en_q[1]) && !(sts_q[2] && en_q[2]) |-> !sci_level);
  p_unmapped_ff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> io_rdata == 8'hFF);
endmodule

bind cpu_presence_evt cpu_presence_evt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .hp_valid(hp_valid),
  .hp_id(hp_id), .hp_add(hp_add), .pm_other_pend(pm_other_pend),
  .sci_level(sci_level), .map_q(map_q), .sts_q(sts_q), .en_q(en_q)
);

// File: tb/test_cpu_presence_evt.sv
module test_cpu_presence_evt;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [255:0] boot_map;
  logic [15:0]  io_addr = 16'h0000;
  logic         io_wr = 0;
  logic [7:0]   io_wdata = 0;
  logic [7:0]   io_rdata;
  logic         hp_valid = 0;
  logic [7:0]   hp_id = 0;
  logic         hp_add = 0;
  logic         pci_evt = 0;
  logic         pm_other_pend = 0;
  logic         sci_level;

  int checks = 0;
  int fails  = 0;
  logic [255:0] model;

  always #10 clk = ~clk;

  cpu_presence_evt i_cpu_presence_evt (
    .clk(clk), .rst_n(rst_n), .boot_map(boot_map), .io_addr(io_addr),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .hp_valid(hp_valid), .hp_id(hp_id), .hp_add(hp_add), .pci_evt(pci_evt),
    .pm_other_pend(pm_other_pend), .sci_level(sci_level)
  );

  function automatic logic boot_bit(input int i);
    return ((i * 7 + 3) % 5) < 2;
  endfunction

  function automatic logic [7:0] model_byte(input int n);
    logic [7:0] b;
    for (int k = 0; k < 8; k++) b[k] = model[n * 8 + k];
    return b;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    io_addr = a;
    #1;
    d = io_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1;
    tick();
    io_wr = 0;
  endtask

  task automatic hp(input logic [7:0] id, input logic add);
    hp_id = id; hp_add = add; hp_valid = 1;
    tick();
    hp_valid = 0;
    model[id] = add;
  endtask

  task automatic run();
    logic [7:0] d;
    for (int i = 0; i < 256; i++) boot_map[i] = boot_bit(i);
    model = boot_map;
    @(negedge clk); tick(); tick();
    rst_n = 1;
    // R1, R2: reset preload, byte layout
    for (int n = 0; n < 32; n++) begin
      rd(16'hAF00 + 16'(n), d); chk("R1/R2 map byte after reset", d, model_byte(n));
    end
    for (int n = 0; n < 4; n++) begin
      rd(16'hAFE0 + 16'(n), d); chk("R1 event regs zero after reset", d, 8'h00);
    end
    chk("R1 sci low after reset", {7'b0, sci_level}, 8'h00);
    // R3, R5: toggle every identifier
    for (int id = 0; id < 256; id++) begin
      hp(8'(id), !model[id]);
      rd(16'hAF00 + 16'(id / 8), d); chk("R3 map byte after request", d, model_byte(id / 8));
      rd(16'hAFE0, d); chk("R5 cpu event bit set", d & 8'h04, 8'h04);
      wr(16'hAFE0, 8'h04);
    end
    for (int n = 0; n < 32; n++) begin
      rd(16'hAF00 + 16'(n), d); chk("R3 full map after sweep", d, model_byte(n));
    end
    // R6: writing 0 keeps, writing 1 clears
    hp(8'd5, 1'b1);
    pci_evt = 1; tick(); pci_evt = 0;
    rd(16'hAFE0, d); chk("R5 both events latched", d, 8'h06);
    wr(16'hAFE0, 8'h00); rd(16'hAFE0, d); chk("R6 zero write no effect", d, 8'h06);
    wr(16'hAFE0, 8'h02); rd(16'hAFE0, d); chk("R6 clear pci bit only", d, 8'h04);
    wr(16'hAFE0, 8'hFF); rd(16'hAFE0, d); chk("R6 clear all", d, 8'h00);
    rd(16'hAFE1, d); chk("R6 second status byte", d, 8'h00);
    // R4: map writes ignored
    for (int n = 0; n < 32; n++) wr(16'hAF00 + 16'(n), ~model_byte(n));
    for (int n = 0; n < 32; n++) begin
      rd(16'hAF00 + 16'(n), d); chk("R4 map unchanged by write", d, model_byte(n));
    end
    // R7: enables
    for (int v = 0; v < 256; v += 17) begin
      wr(16'hAFE2, 8'(v)); wr(16'hAFE3, 8'(~v));
      rd(16'hAFE2, d); chk("R7 enable byte 0", d, 8'(v));
      rd(16'hAFE3, d); chk("R7 enable byte 1", d, 8'(~v));
    end
    rd(16'hAFE0, d); chk("R7 enable write leaves status", d, 8'h00);
    // R9: interrupt level over all enable/event combinations
    for (int en = 0; en < 8; en++) begin
      for (int ev = 0; ev < 4; ev++) begin
        for (int oth = 0; oth < 2; oth++) begin
          wr(16'hAFE0, 8'hFF);
          wr(16'hAFE2, 8'(en));
          if (ev[0]) hp(8'd9, 1'b1);
          if (ev[1]) begin pci_evt = 1; tick(); pci_evt = 0; end
          pm_other_pend = oth[0];
          #1;
          chk("R9 sci level", {7'b0, sci_level},
              {7'b0, (en[2] && ev[0]) || (en[1] && ev[1]) || oth[0]});
          pm_other_pend = 0;
        end
      end
    end
    wr(16'hAFE0, 8'hFF);
    // R8: set wins over same-cycle clear
    io_addr = 16'hAFE0; io_wdata = 8'h04; io_wr = 1;
    hp_id = 8'd200; hp_add = 1'b0; hp_valid = 1;
    tick();
    io_wr = 0; hp_valid = 0; model[200] = 1'b0;
    rd(16'hAFE0, d); chk("R8 set wins over clear", d & 8'h04, 8'h04);
    rd(16'hAF19, d); chk("R8 map still updated", d, model_byte(25));
    // R10: unmapped reads
    rd(16'hAF20, d); chk("R10 above map", d, 8'hFF);
    rd(16'hAEFF, d); chk("R10 below map", d, 8'hFF);
    rd(16'hAFDF, d); chk("R10 below events", d, 8'hFF);
    rd(16'hAFE4, d); chk("R10 above events", d, 8'hFF);
    rd(16'h0000, d); chk("R10 address zero", d, 8'hFF);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule